// File: doc/BRIEF.md
# DRAM Refresh and Wake-up Sequencer

This block sits next to an asynchronous DRAM access controller and owns every refresh cycle the memory sees. After reset it stays quiet for a power-up pause. It then runs a wake-up burst of refresh cycles. Once the burst is done it raises ready. From then on an interval timer marks one owed refresh per slot. The slots are spaced so that all rows are covered within the retention window.

Every refresh is a CAS-before-RAS cycle, so the memory's internal row counter supplies the row and the address bus is not used. The block requests the memory with `ref_req`. The access controller answers with `ref_gnt` once its own cycle and precharge have ended. The block then drives the two strobes until the cycle finishes, and `ref_busy` marks that window.

Owed refreshes accumulate as a debt while grants are held back. If a slot would push the debt past a limit, the retention deadline is treated as missed. The block then raises a sticky overrun flag, drops ready and runs a fresh wake-up burst. All timings are parameters counted in system-clock cycles.

Top module: `rfs_sequencer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `ras_n` and `cas_n` are 1 and `ref_req`, `ready` and `overrun` are 0.
- R2: For the first PAUSE_CYC clock edges after reset is released, `ref_req` stays 0 and both strobes stay high.
- R3: After the pause, exactly WAKE_COUNT refresh cycles are requested before `ready` rises. `ready` rises in the cycle after the last of them finishes.
- R4: A grant to a pending request starts a refresh cycle in the next clock. That cycle has SETUP_CYC cycles with `cas_n`=0 and `ras_n`=1, then ROW_CYC cycles with both strobes at 0, then PRECH_CYC cycles with both at 1. RAS therefore never falls while CAS is high.
- R5: `ref_req` is 1 only when refresh work is pending and no refresh cycle is in progress. `ref_busy` is 1 exactly while the strobes are owned. A `ref_gnt` that arrives with no request is ignored and leaves the strobes high.
- R6: The interval timer starts when the pause ends and ticks every INTERVAL_CYC cycles. While ready, each tick adds one owed refresh and each finished cycle repays one. `ref_req` stays asserted while any debt remains.
- R7: Ticks that occur while `ready` is 0 add no debt.
- R8: When a tick would raise the debt above DEBT_LIMIT, `overrun` goes to 1 and stays 1 until reset. In the same step `ready` drops, the debt is cleared and a new burst of WAKE_COUNT cycles begins.
- R9: `ready` is 0 throughout any wake-up burst. A refresh cycle already running when an overrun hits is completed and counts toward the new burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Access controller releases the memory for one refresh cycle |
| ref_req | output | 1 | Refresh cycle wanted |
| ref_busy | output | 1 | Refresh cycle in progress; the sequencer drives the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ready | output | 1 | Pause and wake-up burst complete; normal access allowed |
| overrun | output | 1 | Sticky flag: the refresh debt passed its limit |

## Verification
The embedded assertions check several properties on every cycle. CAS must already be low whenever RAS falls. A refresh cycle is never started while one is running, and no request appears during the pause. Overrun, once set, must hold. Ready may rise only right after a refresh cycle has finished. Other behaviour can only be shown by the bench's grant scenarios, measured against its reference model cycle by cycle. This covers the exact length of each burst, how debt builds up and is repaid, tick spacing, ticks dropped during a burst, and the point at which withheld grants force an overrun.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [1:0] {
        SEQ_PAUSE = 2'd0,
        SEQ_WAKE  = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_ROW   = 2'd2,
        PH_PRECH = 2'd3
    } cbr_phase_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

    function automatic strobe_t strobes_of(cbr_phase_e ph);
        strobe_t s;
        case (ph)
            PH_SETUP: s = '{ras_n: 1'b1, cas_n: 1'b0};
            PH_ROW:   s = '{ras_n: 1'b0, cas_n: 1'b0};
            default:  s = '{ras_n: 1'b1, cas_n: 1'b1};
        endcase
        return s;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int PERIOD = 3120
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end

    assert_timer_range_R6: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));

endmodule

// File: rtl/rfs_cbr_engine.sv
module rfs_cbr_engine import rfs_pkg::*; #(
    parameter int SETUP_CYC = 2,
    parameter int ROW_CYC   = 10,
    parameter int PRECH_CYC = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic ras_n,
    output logic cas_n
);
    localparam int MAXL = max3(SETUP_CYC, ROW_CYC, PRECH_CYC);
    localparam int CW   = (MAXL > 1) ? $clog2(MAXL) : 1;

    cbr_phase_e    phase;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    strobe_t       stb;

    always_comb begin
        case (phase)
            PH_SETUP: last = CW'(SETUP_CYC - 1);
            PH_ROW:   last = CW'(ROW_CYC - 1);
            default:  last = CW'(PRECH_CYC - 1);
        endcase
    end

    assign stb   = strobes_of(phase);
    assign ras_n = stb.ras_n;
    assign cas_n = stb.cas_n;
    assign busy  = (phase != PH_IDLE);
    assign done  = (phase == PH_PRECH) && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (phase == PH_IDLE) begin
            cnt <= '0;
            if (start) phase <= PH_SETUP;
        end else if (cnt == last) begin
            cnt <= '0;
            case (phase)
                PH_SETUP: phase <= PH_ROW;
                PH_ROW:   phase <= PH_PRECH;
                default:  phase <= PH_IDLE;
            endcase
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: CAS must already be low, and have been low, when RAS falls
    assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    // R5: a start is only presented while the engine is idle
    assert_start_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

endmodule

// File: rtl/rfs_sequencer.sv
module rfs_sequencer import rfs_pkg::*; #(
    parameter int PAUSE_CYC     = 40000,
    parameter int WAKE_COUNT    = 8,
    parameter int INTERVAL_CYC  = 3120,
    parameter int DEBT_LIMIT    = 4,
    parameter int SETUP_CYC     = 2,
    parameter int ROW_CYC       = 10,
    parameter int PRECH_CYC     = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ref_busy,
    output logic ras_n,
    output logic cas_n,
    output logic ready,
    output logic overrun
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int WW = $clog2(WAKE_COUNT + 1);
    localparam int DW = $clog2(DEBT_LIMIT + 2);

    seq_mode_e     mode;
    logic [PW-1:0] pause_cnt;
    logic [WW-1:0] wake_left;
    logic [DW-1:0] debt;
    logic [DW:0]   debt_next;
    logic          tick, eng_busy, eng_done, start, pending, over;

    rfs_interval_timer #(.PERIOD(INTERVAL_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .en   (mode != SEQ_PAUSE),
        .tick (tick)
    );

    rfs_cbr_engine #(
        .SETUP_CYC (SETUP_CYC),
        .ROW_CYC   (ROW_CYC),
        .PRECH_CYC (PRECH_CYC)
    ) u_engine (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (eng_busy),
        .done  (eng_done),
        .ras_n (ras_n),
        .cas_n (cas_n)
    );

    always_comb begin
        pending   = ((mode == SEQ_WAKE) && (wake_left != '0)) ||
                    ((mode == SEQ_RUN)  && (debt != '0));
        ref_req   = pending && !eng_busy;
        start     = ref_req && ref_gnt;
        debt_next = {1'b0, debt} + (DW+1)'(tick) - (DW+1)'(eng_done && (debt != '0));
        over      = (mode == SEQ_RUN) && tick && (debt_next > (DW+1)'(DEBT_LIMIT));
    end

    assign ref_busy = eng_busy;
    assign ready    = (mode == SEQ_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= SEQ_PAUSE;
            pause_cnt <= '0;
            wake_left <= '0;
            debt      <= '0;
            overrun   <= 1'b0;
        end else begin
            case (mode)
                SEQ_PAUSE: begin
                    if (pause_cnt == PW'(PAUSE_CYC - 1)) begin
                        mode      <= SEQ_WAKE;
                        wake_left <= WW'(WAKE_COUNT);
                    end else begin
                        pause_cnt <= pause_cnt + 1'b1;
                    end
                end
                SEQ_WAKE: begin
                    if (eng_done && (wake_left != '0)) begin
                        wake_left <= wake_left - 1'b1;
                        if (wake_left == WW'(1)) begin
                            mode <= SEQ_RUN;
                            debt <= '0;
                        end
                    end
                end
                default: begin
                    if (over) begin
                        overrun   <= 1'b1;
                        mode      <= SEQ_WAKE;
                        wake_left <= WW'(WAKE_COUNT);
                        debt      <= '0;
                    end else begin
                        debt <= debt_next[DW-1:0];
                    end
                end
            endcase
        end
    end

    // R2: nothing happens on the memory during the power-up pause
    assert_pause_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == SEQ_PAUSE) |-> (ras_n && cas_n && !ref_req));

    // R3: ready only rises right after a refresh cycle has completed
    assert_ready_after_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(eng_done));

    // R5: no request while a refresh cycle is in progress
    assert_no_req_busy_R5: assert property (@(posedge clk) disable iff (rst)
        ref_busy |-> !ref_req);

    // R8: overrun is sticky
    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    // R8: the step that raises overrun also leaves ready low
    assert_overrun_drops_ready_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> !ready);

endmodule

// File: tb/test_rfs_sequencer.sv
`timescale 1ns/1ps
module test_rfs_sequencer;

    localparam int PAUSE = 50;
    localparam int WAKE  = 8;
    localparam int INTV  = 40;
    localparam int LIM   = 3;
    localparam int SETUP = 2;
    localparam int ROW   = 4;
    localparam int PRE   = 3;
    localparam int RUN_CYCLES = 1600;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_gnt = 1'b0;
    logic ref_req, ref_busy, ras_n, cas_n, ready, overrun;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    rfs_sequencer #(
        .PAUSE_CYC(PAUSE), .WAKE_COUNT(WAKE), .INTERVAL_CYC(INTV),
        .DEBT_LIMIT(LIM), .SETUP_CYC(SETUP), .ROW_CYC(ROW), .PRECH_CYC(PRE)
    ) i_rfs_sequencer (
        .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .ref_busy(ref_busy), .ras_n(ras_n), .cas_n(cas_n),
        .ready(ready), .overrun(overrun)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference model state
    int mm, mp, mt, mw, md, movr;
    logic [1:0] pat[$];
    bit seen_ovr, seen_ready, seen_spurious;

    function automatic bit grant_policy(int i);
        if (i < 400)       return 1'b1;
        else if (i < 700)  return (i % 7) == 0;
        else if (i < 1000) return 1'b0;
        else if (i < 1300) return 1'b1;
        else               return (i % 3) != 0;
    endfunction

    initial begin
        mm = 0; mp = 0; mt = 0; mw = 0; md = 0; movr = 0;
        repeat (4) begin
            @(negedge clk);
            // R1: reset state
            check(ras_n && cas_n, "R1 strobes", {ras_n, cas_n}, 3);
            check(!ref_req && !ready && !overrun && !ref_busy, "R1 flags",
                  {ref_req, ready, overrun, ref_busy}, 0);
        end
        rst = 1'b0;
        for (int i = 0; i < RUN_CYCLES; i++) begin
            logic [1:0] e_stb;
            bit e_req, e_busy, e_ready, done, tick, g;
            int nd;
            e_busy  = pat.size() > 0;
            e_stb   = e_busy ? pat[0] : 2'b11;
            e_req   = !e_busy && ((mm == 1 && mw > 0) || (mm == 2 && md > 0));
            e_ready = (mm == 2);
            // R4: strobe shape; R2: quiet pause
            check({ras_n, cas_n} == e_stb, (mm == 0) ? "R2 strobes" : "R4 strobes",
                  {ras_n, cas_n}, e_stb);
            // R5 R6 R7: request tracks pending work and idle engine
            check(ref_req == e_req, "R5 R6 R7 ref_req", ref_req, e_req);
            check(ref_busy == e_busy, "R5 ref_busy", ref_busy, e_busy);
            // R3 R9: ready only after a full burst
            check(ready == e_ready, "R3 R9 ready", ready, e_ready);
            // R8: sticky overrun
            check(overrun == (movr != 0), "R8 overrun", overrun, movr);
            if (i == PAUSE - 1)
                check(!ref_req, "R2 end of pause", ref_req, 0);
            if (i == PAUSE)
                check(ref_req, "R3 first wake request", ref_req, 1);
            if (ready) seen_ready = 1;
            if (overrun) seen_ovr = 1;

            g = grant_policy(i);
            if (g && !e_req) seen_spurious = 1;
            ref_gnt = g;

            done = (pat.size() == 1);
            tick = (mm != 0) && (mt == INTV - 1);
            if (pat.size() > 0) void'(pat.pop_front());
            if (e_req && g) begin
                repeat (SETUP) pat.push_back(2'b10);
                repeat (ROW)   pat.push_back(2'b00);
                repeat (PRE)   pat.push_back(2'b11);
            end
            if (mm != 0) mt = (mt == INTV - 1) ? 0 : mt + 1;
            case (mm)
                0: begin
                    if (mp == PAUSE - 1) begin mm = 1; mw = WAKE; end
                    else mp++;
                end
                1: begin
                    if (done && mw > 0) begin
                        if (mw == 1) begin mm = 2; md = 0; end
                        mw--;
                    end
                end
                default: begin
                    nd = md + (tick ? 1 : 0) - ((done && md > 0) ? 1 : 0);
                    if (tick && nd > LIM) begin
                        movr = 1; mm = 1; mw = WAKE; md = 0;
                    end else md = nd;
                end
            endcase
            @(negedge clk);
        end
        check(seen_ready, "R3 ready reached", seen_ready, 1);
        check(seen_ovr, "R8 overrun reached", seen_ovr, 1);
        check(seen_spurious, "R5 unrequested grant exercised", seen_spurious, 1);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule